// File: doc/BRIEF.md
# Serial Pattern Detector with History Lockout

The block watches a one-bit serial stream, one bit per clock, and raises two
single-cycle flags. The trip flag rises whenever the three most recent bits,
oldest first, read 0 then 1 then 0. The arm flag rises whenever they read
1 then 0 then 0, but only while the stream since the last reset has never
contained the trip pattern.

Both flags are Mealy outputs. Each one is high during the same cycle that the
completing bit is presented on `din`, so a consumer samples them at the edge
where that bit is taken. Matches may overlap: the tail of one match can start
the next. The first trip match closes the arm flag for good. Only a synchronous
reset opens it again. Reset also discards every bit received so far, so a
pattern can only be formed from bits presented after reset is released.

Both matchers read one shared history register. A single sticky bit records
whether the trip pattern has been seen.

Top module: `seq_lockout_detector`

## Requirements
- R1: In the first two cycles after reset is released, both flags stay 0 whatever `din` holds, because a full three-bit window does not exist yet.
- R2: `trip_match` is 1 in exactly those cycles where the last three post-reset bits, oldest first, are 0,1,0 (the current `din` is the last bit). In every other cycle it is 0.
- R3: Trip matches overlap. The stream 0,1,0,1,0 raises `trip_match` on its third and fifth bits.
- R4: While no trip match has occurred since reset, `arm_match` is 1 in exactly those cycles where the last three bits, oldest first, are 1,0,0. This can happen more than once, for example on 1,1,0,0 repeated.
- R5: After a trip match, `arm_match` stays 0 on every later 1,0,0 window until reset, and `trip_match` keeps reporting later 0,1,0 windows.
- R6: In the stream 0,1,0,0, `trip_match` is 1 on the third bit. `arm_match` is 0 on the fourth bit, because the lockout already holds.
- R7: A synchronous reset clears the lockout. A 1,0,0 window formed after reset raises `arm_match` again.
- R8: While `rst` is 1, both flags are 0, and the clearing takes effect at the clock edge.
- R9: Bits presented before reset or while it is high never take part in a window. The stream 0 (under reset), then 1, then 0 does not raise `trip_match`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes on the rising edge. |
| rst | input | 1 | Synchronous active-high reset. Clears the history and the lockout. |
| din | input | 1 | Serial data bit, one per cycle. |
| arm_match | output | 1 | High in the cycle that completes 1,0,0, while no 0,1,0 has occurred since reset. |
| trip_match | output | 1 | High in the cycle that completes 0,1,0. |

## Verification
The hardest state to reach is the lockout holding while a 1,0,0 window completes. The stimulus has to produce 0,1,0 first and only afterwards a fresh 1,0,0, and both windows must be formed from post-reset bits only. The vector table builds this in two ways: directly through the 0,1,0,0 overlap, and later through a 1,1,0,0 run after several trip matches. It then resets and repeats 1,0,0 to show the lock has opened again. A long pseudo-random stream with occasional resets follows. It is compared against a bench model built from its own three-bit shift register, fill counter and sticky flag, and it reaches lockout, relock and reset-mid-pattern many times.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    // Default window length and the two patterns; the oldest bit is the MSB.
    localparam int unsigned DEF_PAT_LEN = 3;
    localparam logic [DEF_PAT_LEN-1:0] DEF_TRIP_PAT = 3'b010;
    localparam logic [DEF_PAT_LEN-1:0] DEF_ARM_PAT  = 3'b100;

    // Index of each matcher in the generated matcher array.
    localparam int unsigned IDX_ARM  = 0;
    localparam int unsigned IDX_TRIP = 1;
    localparam int unsigned NUM_PATS = 2;

    typedef struct packed {
        logic trip;
        logic arm;
    } hit_pair_t;

    // Output qualification: reset forces both low; the arm hit is dropped
    // once locked, or when a trip completes in the same cycle.
    function automatic hit_pair_t resolve_hits(hit_pair_t raw, logic locked,
                                               logic in_reset);
        hit_pair_t r;
        r.trip = raw.trip & ~in_reset;
        r.arm  = raw.arm & ~raw.trip & ~locked & ~in_reset;
        return r;
    endfunction

endpackage

// File: rtl/seqdet_history.sv
module seqdet_history #(
    parameter int unsigned PAT_LEN = seqdet_pkg::DEF_PAT_LEN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    output logic [PAT_LEN-1:0] window,
    output logic               full
);
    localparam int unsigned HIST_W = PAT_LEN - 1;
    localparam int unsigned CNT_W  = (PAT_LEN > 2) ? $clog2(PAT_LEN) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(HIST_W);

    logic [HIST_W-1:0] bits_q;
    logic [CNT_W-1:0]  fill_q;

    // Current bit joins the stored bits to form the compare window.
    assign window = {bits_q, din};
    assign full   = (fill_q == FULL_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            fill_q <= '0;
        end else begin
            bits_q <= window[HIST_W-1:0];
            if (!full) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/seqdet_matcher.sv
module seqdet_matcher #(
    parameter int unsigned             PAT_LEN = seqdet_pkg::DEF_PAT_LEN,
    parameter logic [PAT_LEN-1:0]      PATTERN = '0
) (
    input  logic [PAT_LEN-1:0] window,
    input  logic               full,
    output logic               hit
);
    assign hit = full && (window == PATTERN);
endmodule

// File: rtl/seqdet_lockout.sv
module seqdet_lockout (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
        end else if (set) begin
            locked <= 1'b1;
        end
    end
endmodule

// File: rtl/seq_lockout_detector.sv
module seq_lockout_detector #(
    parameter int unsigned        PAT_LEN  = seqdet_pkg::DEF_PAT_LEN,
    parameter logic [PAT_LEN-1:0] TRIP_PAT = seqdet_pkg::DEF_TRIP_PAT,
    parameter logic [PAT_LEN-1:0] ARM_PAT  = seqdet_pkg::DEF_ARM_PAT
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic arm_match,
    output logic trip_match
);
    import seqdet_pkg::*;

    localparam logic [NUM_PATS-1:0][PAT_LEN-1:0] PATS = {TRIP_PAT, ARM_PAT};

    logic [PAT_LEN-1:0]  window;
    logic                full;
    logic [NUM_PATS-1:0] hits;
    logic                locked;
    hit_pair_t           raw_hits;
    hit_pair_t           out_hits;

    seqdet_history #(.PAT_LEN(PAT_LEN)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .window (window),
        .full   (full)
    );

    for (genvar g = 0; g < NUM_PATS; g++) begin : g_match
        seqdet_matcher #(
            .PAT_LEN (PAT_LEN),
            .PATTERN (PATS[g])
        ) u_match (
            .window (window),
            .full   (full),
            .hit    (hits[g])
        );
    end

    assign raw_hits.trip = hits[IDX_TRIP];
    assign raw_hits.arm  = hits[IDX_ARM];

    seqdet_lockout u_lock (
        .clk    (clk),
        .rst    (rst),
        .set    (raw_hits.trip),
        .locked (locked)
    );

    assign out_hits   = resolve_hits(raw_hits, locked, rst);
    assign arm_match  = out_hits.arm;
    assign trip_match = out_hits.trip;

endmodule

// File: rtl/seqdet_checker.sv
module seqdet_checker #(
    parameter int unsigned PAT_LEN = seqdet_pkg::DEF_PAT_LEN
) (
    input logic clk,
    input logic rst,
    input logic din,
    input logic arm_match,
    input logic trip_match
);
    localparam int unsigned CNT_W = (PAT_LEN > 2) ? $clog2(PAT_LEN) : 1;
    localparam logic [CNT_W-1:0] WARM = CNT_W'(PAT_LEN - 1);

    logic [CNT_W-1:0] since_q;
    logic             seen_trip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q     <= '0;
            seen_trip_q <= 1'b0;
        end else begin
            if (since_q != WARM) since_q <= since_q + 1'b1;
            if (trip_match) seen_trip_q <= 1'b1;
        end
    end

    // R1: no flag before a full window of post-reset bits exists
    assert_warmup_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (since_q != WARM) |-> (!arm_match && !trip_match));

    // R2: a trip flag ends in 1 then 0
    assert_trip_tail_R2: assert property (@(posedge clk) disable iff (rst)
        trip_match |-> (!din && $past(din)));

    // R4: an arm flag ends in 0 then 0
    assert_arm_tail_R4: assert property (@(posedge clk) disable iff (rst)
        arm_match |-> (!din && !$past(din)));

    // R4: the two flags never fire together
    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(arm_match && trip_match));

    // R5: once a trip was reported, arm stays low until reset
    assert_locked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        seen_trip_q |-> !arm_match);

    // R8: both flags low while reset is held
    assert_reset_quiet_R8: assert property (@(posedge clk)
        rst |-> (!arm_match && !trip_match));

endmodule

bind seq_lockout_detector seqdet_checker #(.PAT_LEN(PAT_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .arm_match  (arm_match),
    .trip_match (trip_match)
);

// File: tb/tb_seq_lockout_detector.sv
`timescale 1ns/1ps
module tb_seq_lockout_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic arm_match;
    logic trip_match;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    seq_lockout_detector dut (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .arm_match  (arm_match),
        .trip_match (trip_match)
    );

    // Row layout: {rst, din, expected arm, expected trip, requirement number}
    localparam int NVEC = 24;
    localparam logic [7:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 reset held
        {1'b1, 1'b1, 1'b0, 1'b0, 4'd8}, // R8
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd1}, // R1 first bit
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd1}, // R1 second bit
        {1'b0, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 1,0,0
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 0,0,1
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 0,1,1
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 1,1,0
        {1'b0, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 second 1,0,0
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2
        {1'b0, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 0,1,0
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 0,1,0,0
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3
        {1'b0, 1'b0, 1'b0, 1'b1, 4'd3}, // R3
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3
        {1'b0, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 overlapped trip
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd5}, // R5
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd5}, // R5
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 1,0,0 while locked
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 reset mid-stream
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd9}, // R9
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 no window across reset
        {1'b0, 1'b0, 1'b1, 1'b0, 4'd7}  // R7 lock cleared
    };

    function automatic string req_name(logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic check_out(string req, logic exp_arm, logic exp_trip, int idx);
        checks++;
        if (arm_match !== exp_arm || trip_match !== exp_trip) begin
            failures++;
            $display("FAIL %s step %0d: arm=%b trip=%b expected arm=%b trip=%b",
                     req, idx, arm_match, trip_match, exp_arm, exp_trip);
        end
    endtask

    // Drive one cycle: set inputs after the falling edge, sample 1 ns later.
    task automatic apply(logic r, logic d);
        @(negedge clk);
        rst = r;
        din = d;
        #1;
    endtask

    // Independent bench model: three-bit shift register, fill count, sticky flag.
    logic [2:0] m_hist = '0;
    int         m_fill = 0;
    bit         m_lock = 1'b0;

    initial begin
        // Reset state, R8
        apply(1'b1, 1'b0);
        check_out("R8", 1'b0, 1'b0, -1);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][7], VEC[i][6]);
            check_out(req_name(VEC[i][3:0]), VEC[i][5], VEC[i][4], i);
        end

        // Pseudo-random stream against the model (R2 R4 R5 R7 R9)
        begin
            logic [15:0] lfsr = 16'hACE1;
            apply(1'b1, 1'b0);
            m_hist = '0; m_fill = 0; m_lock = 1'b0;
            for (int n = 0; n < 600; n++) begin
                logic r, d, w_ok, e_arm, e_trip;
                logic [2:0] win;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                r = (lfsr[15:11] == 5'd0);
                d = lfsr[0] ^ lfsr[7];
                apply(r, d);
                win    = {m_hist[1:0], d};
                w_ok   = (m_fill >= 2);
                e_trip = !r && w_ok && (win == 3'b010);
                e_arm  = !r && w_ok && (win == 3'b100) && !m_lock;
                check_out(e_trip ? "R2" : (m_lock ? "R5" : "R4"), e_arm, e_trip, 1000 + n);
                if (r) begin
                    m_hist = '0; m_fill = 0; m_lock = 1'b0;
                end else begin
                    m_hist = win;
                    if (m_fill < 2) m_fill++;
                    if (e_trip) m_lock = 1'b1;
                end
            end
        end

        // Directed: 1,1,0,0 repeated twice with no trip in between, R4
        apply(1'b1, 1'b0);
        apply(1'b0, 1'b1); apply(1'b0, 1'b1); apply(1'b0, 1'b0);
        apply(1'b0, 1'b0); check_out("R4", 1'b1, 1'b0, 2000);
        apply(1'b0, 1'b1); apply(1'b0, 1'b1); apply(1'b0, 1'b0);
        apply(1'b0, 1'b0); check_out("R4", 1'b1, 1'b0, 2001);

        // Directed: reset while 0,1 pending, R8 then R9
        apply(1'b0, 1'b0); apply(1'b0, 1'b1);
        apply(1'b1, 1'b0); check_out("R8", 1'b0, 1'b0, 2002);
        apply(1'b0, 1'b0); check_out("R9", 1'b0, 1'b0, 2003);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule